// File: doc/BRIEF.md
# Four-Way Page Translation Buffer with Tree Replacement

This block caches page translations for an address-translation unit. A lookup presents a 20-bit linear page number together with the access privilege (user or supervisor) and direction (read or write). Within the same cycle the block answers with a hit indication, the 20-bit physical page number, two cache-control attributes (no-cache and write-through) and a protection-fault flag. A write that lands on a clean entry is refused and reported separately, so the page walker can mark the page dirty and reload it.

Storage is 8 sets of 4 ways, 32 translations in all. Each set keeps a 3-bit binary-tree pseudo-LRU state. A refill from the walker goes into the way that tree points at, even when a different way of the same set is empty. A single flush pulse empties the whole buffer and resets every tree.

Top module: `tlb_plru`

## Requirements
- R1: After reset every lookup misses (`lk_hit`=0) and `fill_way` reads 0 for any set.
- R2: The set is `lk_lpn[2:0]` and the tag is `lk_lpn[19:3]`. A lookup hits in the same cycle when a valid way of that set holds the tag, and it then returns that way's physical page, no-cache bit and write-through bit. Any other lookup misses.
- R3: When `fill_en` is high at a rising edge, the translation is stored in the way shown on `fill_way` for the set `fill_lpn[2:0]`, and it is valid from the next cycle.
- R4: The victim is taken from the tree state alone and ignores validity. The state bits are b0, b1 and b2. b0=0 selects way b1 (0 or 1) and b0=1 selects way 2+b2. After a flush a set fills in the order 0, 2, 1, 3. A valid way is chosen even while another way of the set is empty.
- R5: A hit or a fill to way w updates the tree of its set at the next edge. For w<2 it sets b0=1 and b1=~w[0]. For w>=2 it sets b0=0 and b2=~w[0]. The other bit is left alone.
- R6: A hit raises `lk_fault` when the access is user-mode and the entry is supervisor-only, or when it is a user-mode write and the entry is read-only. A faulting lookup still reports `lk_hit`=1. Supervisor accesses never fault.
- R7: A non-faulting write that matches an entry whose dirty bit is clear gives `lk_hit`=0 and `lk_dirty_upd`=1. `lk_dirty_upd` is 0 in every other case.
- R8: The tree changes on a lookup only when `lk_valid` is high and the lookup hits. A lookup with `lk_valid` low leaves the tree unchanged.
- R9: When a fill and a tree-updating hit fall on the same set in the same cycle, the fill's update wins.
- R10: A flush pulse invalidates all 32 entries and clears all trees in one cycle. A fill in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and clear the replacement state |
| lk_valid | input | 1 | Lookup is real and may update the replacement state |
| lk_lpn | input | 20 | Linear page number to translate |
| lk_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_hit | output | 1 | Translation found and usable |
| lk_fault | output | 1 | Protection violation on a matching entry |
| lk_dirty_upd | output | 1 | Write matched a clean entry; walker must set dirty |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_nocache | output | 1 | Page no-cache attribute of the hit |
| lk_wthru | output | 1 | Page write-through attribute of the hit |
| fill_en | input | 1 | Store a new translation at the next edge |
| fill_lpn | input | 20 | Linear page of the new translation |
| fill_ppn | input | 20 | Physical page of the new translation |
| fill_nocache | input | 1 | No-cache attribute to store |
| fill_wthru | input | 1 | Write-through attribute to store |
| fill_user_ok | input | 1 | 1 = user mode may access the page |
| fill_writable | input | 1 | 1 = user mode may write the page |
| fill_dirty | input | 1 | Dirty bit to store |
| fill_way | output | 2 | Victim way for the set of `fill_lpn` |

## Verification
A refill and a hit can both target the tree of one set in the same cycle, and so can a flush and a refill. The bench provokes the first case by raising `fill_en` while a valid lookup hits in the same set. It chooses the hit way and the victim so that the two candidate outcomes leave different next victims on `fill_way`, which shows which update was kept. It provokes the second case by pulsing flush together with a fill, and then checks that the filled page misses and the victim has returned to way 0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int LPN_W    = 20;
    localparam int PPN_W    = 20;
    localparam int NUM_SETS = 8;
    localparam int NUM_WAYS = 4;   // the tree below is written for four ways
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int TAG_W    = LPN_W - SET_W;
    localparam int TREE_W   = NUM_WAYS - 1;

    typedef logic [SET_W-1:0]  set_idx_t;
    typedef logic [WAY_W-1:0]  way_idx_t;
    typedef logic [TREE_W-1:0] tree_t;

    typedef struct packed {
        logic             valid;
        logic             user_ok;
        logic             writable;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } tag_ent_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             nocache;
        logic             wthru;
    } data_ent_t;

    function automatic set_idx_t lpn_set(input logic [LPN_W-1:0] lpn);
        return lpn[SET_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] lpn_tag(input logic [LPN_W-1:0] lpn);
        return lpn[LPN_W-1:SET_W];
    endfunction

    // b0 picks the pair, b1 / b2 pick inside the low / high pair
    function automatic way_idx_t tree_victim(input tree_t b);
        if (!b[0]) return {1'b0, b[1]};
        else       return {1'b1, b[2]};
    endfunction

    // steer the path away from the way just used
    function automatic tree_t tree_touch(input tree_t b, input way_idx_t w);
        tree_t n;
        n = b;
        if (!w[1]) begin
            n[0] = 1'b1;
            n[1] = ~w[0];
        end else begin
            n[0] = 1'b0;
            n[2] = ~w[0];
        end
        return n;
    endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  set_idx_t         wr_set,
    input  tag_ent_t         wr_tag,
    input  data_ent_t        wr_data,
    input  set_idx_t         rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             match,
    output tag_ent_t         rd_tag_ent,
    output data_ent_t        rd_data
);

    tag_ent_t  tag_q  [NUM_SETS];
    data_ent_t data_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tag_q[s].valid <= 1'b0;
            end
        end else if (wr_en) begin
            tag_q[wr_set] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            data_q[wr_set] <= wr_data;
        end
    end

    always_comb begin
        rd_tag_ent = tag_q[rd_set];
        rd_data    = data_q[rd_set];
        match      = rd_tag_ent.valid && (rd_tag_ent.tag == rd_tag);
    end

endmodule

// File: rtl/tlb_tree_lru.sv
module tlb_tree_lru
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     hit_en,
    input  set_idx_t hit_set,
    input  way_idx_t hit_way,
    input  logic     fill_en,
    input  set_idx_t fill_set,
    output way_idx_t victim
);

    tree_t tree_q [NUM_SETS];

    assign victim = tree_victim(tree_q[fill_set]);

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    tree_q[s] <= '0;
                end else if (fill_en && fill_set == set_idx_t'(s)) begin
                    tree_q[s] <= tree_touch(tree_q[s], victim);
                end else if (hit_en && hit_set == set_idx_t'(s)) begin
                    tree_q[s] <= tree_touch(tree_q[s], hit_way);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tlb_access_chk.sv
module tlb_access_chk
    import tlb_pkg::*;
(
    input  logic     match,
    input  tag_ent_t ent,
    input  logic     user,
    input  logic     write,
    output logic     hit,
    output logic     fault,
    output logic     dirty_upd
);

    always_comb begin
        fault     = match && user && (!ent.user_ok || (write && !ent.writable));
        dirty_upd = match && !fault && write && !ent.dirty;
        hit       = match && !dirty_upd;
    end

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [LPN_W-1:0] lk_lpn,
    input  logic             lk_user,
    input  logic             lk_write,
    output logic             lk_hit,
    output logic             lk_fault,
    output logic             lk_dirty_upd,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_nocache,
    output logic             lk_wthru,
    input  logic             fill_en,
    input  logic [LPN_W-1:0] fill_lpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_nocache,
    input  logic             fill_wthru,
    input  logic             fill_user_ok,
    input  logic             fill_writable,
    input  logic             fill_dirty,
    output logic [WAY_W-1:0] fill_way
);

    logic [NUM_WAYS-1:0] way_match;
    tag_ent_t            way_tag  [NUM_WAYS];
    data_ent_t           way_data [NUM_WAYS];

    set_idx_t  rd_set;
    set_idx_t  wr_set;
    tag_ent_t  new_tag;
    data_ent_t new_data;
    way_idx_t  victim;
    way_idx_t  sel_way;
    tag_ent_t  sel_tag;
    data_ent_t sel_data;
    logic      any_match;
    logic      lru_hit_en;

    assign rd_set = lpn_set(lk_lpn);
    assign wr_set = lpn_set(fill_lpn);

    always_comb begin
        new_tag.valid    = 1'b1;
        new_tag.user_ok  = fill_user_ok;
        new_tag.writable = fill_writable;
        new_tag.dirty    = fill_dirty;
        new_tag.tag      = lpn_tag(fill_lpn);
        new_data.ppn     = fill_ppn;
        new_data.nocache = fill_nocache;
        new_data.wthru   = fill_wthru;
    end

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            tlb_way u_way (
                .clk        (clk),
                .rst        (rst),
                .flush      (flush),
                .wr_en      (fill_en && !flush && victim == way_idx_t'(w)),
                .wr_set     (wr_set),
                .wr_tag     (new_tag),
                .wr_data    (new_data),
                .rd_set     (rd_set),
                .rd_tag     (lpn_tag(lk_lpn)),
                .match      (way_match[w]),
                .rd_tag_ent (way_tag[w]),
                .rd_data    (way_data[w])
            );
        end
    endgenerate

    // lowest matching way wins if a tag were ever duplicated
    always_comb begin
        sel_way   = '0;
        sel_tag   = way_tag[0];
        sel_data  = way_data[0];
        any_match = 1'b0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) begin
                sel_way   = way_idx_t'(w);
                sel_tag   = way_tag[w];
                sel_data  = way_data[w];
                any_match = 1'b1;
            end
        end
    end

    tlb_access_chk u_access (
        .match     (any_match),
        .ent       (sel_tag),
        .user      (lk_user),
        .write     (lk_write),
        .hit       (lk_hit),
        .fault     (lk_fault),
        .dirty_upd (lk_dirty_upd)
    );

    assign lru_hit_en = lk_valid && lk_hit;

    tlb_tree_lru u_lru (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .hit_en   (lru_hit_en),
        .hit_set  (rd_set),
        .hit_way  (sel_way),
        .fill_en  (fill_en && !flush),
        .fill_set (wr_set),
        .victim   (victim)
    );

    assign fill_way   = victim;
    assign lk_ppn     = sel_data.ppn;
    assign lk_nocache = sel_data.nocache;
    assign lk_wthru   = sel_data.wthru;

endmodule

// File: rtl/tlb_plru_props.sv
module tlb_plru_props
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic [LPN_W-1:0] lk_lpn,
    input logic             lk_user,
    input logic             lk_write,
    input logic             lk_hit,
    input logic             lk_fault,
    input logic             lk_dirty_upd,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             fill_en,
    input logic [LPN_W-1:0] fill_lpn,
    input logic [PPN_W-1:0] fill_ppn,
    input logic [WAY_W-1:0] fill_way
);

    // R6
    fault_needs_user_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> (lk_hit && lk_user));

    // R7
    dirty_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        lk_dirty_upd |-> (lk_write && !lk_hit && !lk_fault));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!lk_hit && !lk_fault && !lk_dirty_upd));

    // R10
    flush_clears_tree_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill_way == '0));

    // R3
    fill_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fill_en) && !$past(flush) && !flush && !lk_write
         && lk_lpn == $past(fill_lpn))
        |-> (lk_hit && lk_ppn == $past(fill_ppn)));

endmodule

bind tlb_plru tlb_plru_props u_props (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .lk_lpn       (lk_lpn),
    .lk_user      (lk_user),
    .lk_write     (lk_write),
    .lk_hit       (lk_hit),
    .lk_fault     (lk_fault),
    .lk_dirty_upd (lk_dirty_upd),
    .lk_ppn       (lk_ppn),
    .fill_en      (fill_en),
    .fill_lpn     (fill_lpn),
    .fill_ppn     (fill_ppn),
    .fill_way     (fill_way)
);

// File: tb/tlb_plru_tb.sv
module tlb_plru_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_lpn = '0;
    logic        lk_user = 1'b0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_fault, lk_dirty_upd, lk_nocache, lk_wthru;
    logic [19:0] lk_ppn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_lpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_nocache = 1'b0, fill_wthru = 1'b0;
    logic        fill_user_ok = 1'b0, fill_writable = 1'b0, fill_dirty = 1'b0;
    logic [1:0]  fill_way;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tlb_plru u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_valid(lk_valid), .lk_lpn(lk_lpn), .lk_user(lk_user), .lk_write(lk_write),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_dirty_upd(lk_dirty_upd),
        .lk_ppn(lk_ppn), .lk_nocache(lk_nocache), .lk_wthru(lk_wthru),
        .fill_en(fill_en), .fill_lpn(fill_lpn), .fill_ppn(fill_ppn),
        .fill_nocache(fill_nocache), .fill_wthru(fill_wthru),
        .fill_user_ok(fill_user_ok), .fill_writable(fill_writable),
        .fill_dirty(fill_dirty), .fill_way(fill_way)
    );

    // all in set 1 (low three bits 001), distinct tags
    localparam logic [19:0] PG_A = 20'h12341, PG_B = 20'h2A5F9, PG_C = 20'h00011;
    localparam logic [19:0] PG_D = 20'hFFFF9, PG_E = 20'h55551;
    localparam logic [19:0] PH_A = 20'hAAAA0, PH_B = 20'hBBBB1, PH_C = 20'hCCCC2;
    localparam logic [19:0] PH_D = 20'hDDDD3, PH_E = 20'hEEEE4;

    typedef struct packed {
        logic [19:0] lpn;
        logic        user;
        logic        write;
        logic        hit;
        logic [19:0] ppn;
        logic        nc;
        logic        wt;
        logic        fault;
        logic        dupd;
    } vec_t;

    // A: user rw dirty; B: supervisor only; C: user read-only; D: user rw clean
    localparam vec_t VECS [12] = '{
        '{PG_A, 1'b0, 1'b0, 1'b1, PH_A, 1'b1, 1'b0, 1'b0, 1'b0},
        '{PG_A, 1'b1, 1'b1, 1'b1, PH_A, 1'b1, 1'b0, 1'b0, 1'b0},
        '{PG_B, 1'b1, 1'b0, 1'b1, PH_B, 1'b0, 1'b1, 1'b1, 1'b0},
        '{PG_B, 1'b0, 1'b1, 1'b1, PH_B, 1'b0, 1'b1, 1'b0, 1'b0},
        '{PG_B, 1'b1, 1'b1, 1'b1, PH_B, 1'b0, 1'b1, 1'b1, 1'b0},
        '{PG_C, 1'b1, 1'b1, 1'b1, PH_C, 1'b1, 1'b1, 1'b1, 1'b0},
        '{PG_C, 1'b0, 1'b1, 1'b1, PH_C, 1'b1, 1'b1, 1'b0, 1'b0},
        '{PG_C, 1'b1, 1'b0, 1'b1, PH_C, 1'b1, 1'b1, 1'b0, 1'b0},
        '{PG_D, 1'b1, 1'b1, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{PG_D, 1'b1, 1'b0, 1'b1, PH_D, 1'b0, 1'b0, 1'b0, 1'b0},
        '{PG_E, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{20'h12342, 1'b0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // inputs change at the falling edge, results are read 1 ns later
    task automatic look(input logic [19:0] lpn, input logic u, input logic w, input logic v);
        @(negedge clk);
        lk_lpn = lpn; lk_user = u; lk_write = w; lk_valid = v;
        #1;
    endtask

    task automatic fill(input logic [19:0] lpn, input logic [19:0] ppn,
                        input logic nc, input logic wt, input logic uo,
                        input logic wr, input logic d, input logic [1:0] exp_way,
                        input string req);
        @(negedge clk);
        lk_valid = 1'b0;
        fill_lpn = lpn; fill_ppn = ppn; fill_nocache = nc; fill_wthru = wt;
        fill_user_ok = uo; fill_writable = wr; fill_dirty = d; fill_en = 1'b1;
        #1;
        chk(fill_way == exp_way, req, "victim way", 32'(fill_way), 32'(exp_way));
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic expect_hit(input logic [19:0] lpn, input logic [19:0] ppn, input string req);
        look(lpn, 1'b0, 1'b0, 1'b0);
        chk(lk_hit == 1'b1, req, "hit", 32'(lk_hit), 32'd1);
        chk(lk_ppn == ppn, req, "ppn", 32'(lk_ppn), 32'(ppn));
    endtask

    task automatic expect_miss(input logic [19:0] lpn, input string req);
        look(lpn, 1'b0, 1'b0, 1'b0);
        chk(lk_hit == 1'b0, req, "miss", 32'(lk_hit), 32'd0);
    endtask

    task automatic do_flush();
        @(negedge clk);
        lk_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset, tree at zero
        fill_lpn = PG_A;
        expect_miss(PG_A, "R1");
        chk(fill_way == 2'd0, "R1", "victim after reset", 32'(fill_way), 32'd0);

        // R4 / R3: fill order 0,2,1,3 from a cleared tree
        fill(PG_A, PH_A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, "R4");
        fill(PG_B, PH_B, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, "R4");
        fill(PG_C, PH_C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, "R4");
        fill(PG_D, PH_D, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, "R4");

        // R2 R6 R7: table of lookups
        for (int i = 0; i < 12; i++) begin
            vec_t v;
            v = VECS[i];
            look(v.lpn, v.user, v.write, 1'b1);
            chk(lk_hit == v.hit, "R2", $sformatf("hit vec %0d", i), 32'(lk_hit), 32'(v.hit));
            chk(lk_fault == v.fault, "R6", $sformatf("fault vec %0d", i), 32'(lk_fault), 32'(v.fault));
            chk(lk_dirty_upd == v.dupd, "R7", $sformatf("dirty vec %0d", i), 32'(lk_dirty_upd), 32'(v.dupd));
            if (v.hit) begin
                chk({lk_ppn, lk_nocache, lk_wthru} == {v.ppn, v.nc, v.wt}, "R2",
                    $sformatf("data vec %0d", i), 32'({lk_ppn, lk_nocache, lk_wthru}),
                    32'({v.ppn, v.nc, v.wt}));
            end
        end

        // R10: flush empties the table
        do_flush();
        expect_miss(PG_D, "R10");
        fill_lpn = PG_A;
        #1;
        chk(fill_way == 2'd0, "R10", "victim after flush", 32'(fill_way), 32'd0);

        // R4: valid way picked while way 3 is still empty
        fill(PG_A, PH_A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, "R4");
        fill(PG_B, PH_B, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, "R4");
        fill(PG_C, PH_C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, "R4");
        look(PG_B, 1'b0, 1'b0, 1'b1);      // hit way 2 -> tree points at way 0
        fill(PG_D, PH_D, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, "R4");
        expect_miss(PG_A, "R4");
        expect_hit(PG_D, PH_D, "R3");
        chk(fill_way == 2'd3, "R5", "victim after fill way0", 32'(fill_way), 32'd3);

        // R5: hits steer the tree
        look(PG_D, 1'b0, 1'b0, 1'b1);      // way 0
        look(PG_B, 1'b0, 1'b0, 1'b1);      // way 2
        look(PG_B, 1'b0, 1'b0, 1'b0);
        chk(fill_way == 2'd1, "R5", "victim after hits", 32'(fill_way), 32'd1);

        // R8: invalid lookup to way 0 must not move the tree
        look(PG_D, 1'b0, 1'b0, 1'b0);
        look(PG_D, 1'b0, 1'b0, 1'b0);
        chk(fill_way == 2'd1, "R8", "victim unchanged", 32'(fill_way), 32'd1);

        // R9: fill (to way 1) and hit (way 2) on set 1 in one cycle
        @(negedge clk);
        lk_lpn = PG_B; lk_user = 1'b0; lk_write = 1'b0; lk_valid = 1'b1;
        fill_lpn = PG_E; fill_ppn = PH_E; fill_user_ok = 1'b1; fill_writable = 1'b1;
        fill_dirty = 1'b1; fill_en = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; lk_valid = 1'b0;
        #1;
        chk(fill_way == 2'd3, "R9", "fill update kept", 32'(fill_way), 32'd3);
        expect_hit(PG_E, PH_E, "R9");
        expect_miss(PG_C, "R9");

        // R10: flush beats a same-cycle fill
        @(negedge clk);
        fill_lpn = PG_C; fill_ppn = PH_C; fill_en = 1'b1; flush = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        expect_miss(PG_C, "R10");
        expect_miss(PG_B, "R10");
        #1;
        chk(fill_way == 2'd0, "R10", "victim after flush+fill", 32'(fill_way), 32'd0);

        finish_run();
    end

endmodule